// File: doc/BRIEF.md
# Splittable Dual 16/32-bit Timer

This block holds two 16-bit down-counter halves, A and B. They can run as two independent timers, each with its own 8-bit prescaler. They can also be fused into one 32-bit counter, with A as the low half and B as the high half. Each timer runs in either one-shot or periodic form. The fused counter has one further mode: it counts up on rising edges of a slow external clock and raises a flag when the count equals a 32-bit compare value.

Software drives the block through a flat register port that is one word wide. A write takes effect on the clock edge that samples it. Read data is registered and valid one cycle after the address is presented. There are three sticky event flags: a timeout for each half and an RTC match. Each flag is cleared by writing a one to its bit. A debug-halt input can freeze any timer whose stall option is set.

Top module: `split_timer`

## Requirements
- R1: After synchronous reset, every register, both counters, all three flags and `rdata` read as zero.
- R2: The addresses are: 0 config, 1 enables, 2 load (A in bits 15:0, B in bits 31:16), 3 load B alone, 4 match, 5 prescale (A in bits 7:0, B in bits 15:8), 6 flags, 7 count {B,A}. `rdata` shows the selected register one clock after `addr` is applied. Config bits are: 0 fused, 1 RTC, 2 periodic A, 3 periodic B, 4 stall A, 5 stall B. Enable bits are: 0 A, 1 B. Flag bits are: 0 timeout A, 1 timeout B, 2 match.
- R3: A one-shot timer decrements once per tick. On a tick where its count is already zero, it sets its timeout flag, clears its own enable bit and stays at zero.
- R4: A periodic timer, on a tick at count zero, sets its timeout flag and reloads its load value. This gives one timeout every load+1 ticks.
- R5: In split mode a half ticks once every prescale+1 clocks. Its first timeout comes (load+1)·(prescale+1) clocks after the enabling write.
- R6: In fused mode the 32-bit count {B,A} decrements once per clock, with the borrow carried from A into B. The enable, periodic and stall bits of A govern it, its timeout sets flag A, and the prescalers have no effect.
- R7: In fused RTC mode the count ignores the system clock. It increments once per synchronised rising edge of `rtc_clk` and wraps at 2^32. It sets the match flag when the new count equals the match register, and it never sets a timeout flag.
- R8: While `halt` is high, a timer with its stall bit set holds its count. A timer without the stall bit keeps counting.
- R9: A load write to a disabled timer also sets its counter. A load write to an enabled timer changes only the reload value.
- R10: A config write while either enable bit is set is ignored.
- R11: Writing one to a flag bit clears that flag. An event in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| halt | input | 1 | Debug halt request |
| rtc_clk | input | 1 | Slow external clock for RTC mode, asynchronous |
| irq_to_a | output | 1 | Timeout flag of timer A (or fused timer) |
| irq_to_b | output | 1 | Timeout flag of timer B |
| irq_match | output | 1 | RTC match flag |

## Verification
The hardest condition to reach is a flag clear landing in exactly the cycle in which a new event fires. The stimulus gets there by running timer A periodic with a load of zero, so that it produces an event on every clock, and then issuing the clear while it runs. A second hard spot is the RTC wrap through zero with a match just past it. The bench preloads the count at 0xFFFFFFFE and drives slow `rtc_clk` pulses, and it first idles for many system clocks to show that nothing moves without those pulses.

// File: rtl/st_pkg.sv
package st_pkg;
  typedef enum logic [2:0] {
    A_CFG   = 3'd0,
    A_CTL   = 3'd1,
    A_LOAD  = 3'd2,
    A_LOADB = 3'd3,
    A_MATCH = 3'd4,
    A_PRE   = 3'd5,
    A_FLAG  = 3'd6,
    A_CNT   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic stall_b;
    logic stall_a;
    logic per_b;
    logic per_a;
    logic rtc;
    logic fused;
  } cfg_t;
endpackage

// File: rtl/st_prescale.sv
module st_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             hold,
  input  logic [PRE_W-1:0] preset,
  output logic             wrap
);
  logic [PRE_W-1:0] cnt;

  assign wrap = active && !hold && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (!active) cnt <= preset;
    else if (!hold)   cnt <= (cnt == '0) ? preset : cnt - 1'b1;
  end

  // R5
  pre_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && preset != '0) |=> !wrap);
endmodule

// File: rtl/st_edge_sync.sv
module st_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= async_in; s2 <= s1; s3 <= s2;
    end
  end

  assign rise = s2 && !s3;

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/st_core.sv
module st_core
  import st_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              halt,
  input  logic              pre_wrap_a,
  input  logic              pre_wrap_b,
  input  logic              rtc_rise,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic [HALF_W-1:0] ld_val_a,
  input  logic [HALF_W-1:0] ld_val_b,
  input  logic [HALF_W-1:0] rel_a,
  input  logic [HALF_W-1:0] rel_b,
  input  logic [2*HALF_W-1:0] match,
  output logic [HALF_W-1:0] cnt_a,
  output logic [HALF_W-1:0] cnt_b,
  output logic              ev_to_a,
  output logic              ev_to_b,
  output logic              ev_match,
  output logic              done_a,
  output logic              done_b
);
  localparam int FULL_W = 2 * HALF_W;

  logic              go_a, go_b, tick_a, tick_b, tick32;
  logic [FULL_W-1:0] cnt32, rel32, inc32, nxt32;
  logic [HALF_W-1:0] nxt_a, nxt_b;

  function automatic logic [HALF_W-1:0] step_down(
    input logic [HALF_W-1:0] cur, input logic [HALF_W-1:0] rel, input logic per);
    if (cur == '0) return per ? rel : cur;
    return cur - 1'b1;
  endfunction

  assign go_a   = en_a && !(cfg.stall_a && halt);
  assign go_b   = en_b && !(cfg.stall_b && halt);
  assign tick_a = go_a && pre_wrap_a;
  assign tick_b = go_b && pre_wrap_b;
  assign tick32 = go_a && (cfg.rtc ? rtc_rise : 1'b1);

  assign cnt32 = {cnt_b, cnt_a};
  assign rel32 = {rel_b, rel_a};
  assign inc32 = cnt32 + 1'b1;
  assign nxt_a = step_down(cnt_a, rel_a, cfg.per_a);
  assign nxt_b = step_down(cnt_b, rel_b, cfg.per_b);

  always_comb begin
    if (cfg.rtc)             nxt32 = inc32;
    else if (cnt32 == '0)    nxt32 = cfg.per_a ? rel32 : cnt32;
    else                     nxt32 = cnt32 - 1'b1;
  end

  always_comb begin
    if (cfg.fused) begin
      ev_to_a  = tick32 && !cfg.rtc && (cnt32 == '0);
      ev_to_b  = 1'b0;
      ev_match = tick32 && cfg.rtc && (inc32 == match);
      done_a   = ev_to_a && !cfg.per_a;
      done_b   = 1'b0;
    end else begin
      ev_to_a  = tick_a && (cnt_a == '0);
      ev_to_b  = tick_b && (cnt_b == '0);
      ev_match = 1'b0;
      done_a   = ev_to_a && !cfg.per_a;
      done_b   = ev_to_b && !cfg.per_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (cfg.fused) begin
      if (ld_a) begin
        cnt_a <= ld_val_a;
        cnt_b <= ld_val_b;
      end else if (tick32) begin
        {cnt_b, cnt_a} <= nxt32;
      end
    end else begin
      if (ld_a)        cnt_a <= ld_val_a;
      else if (tick_a) cnt_a <= nxt_a;
      if (ld_b)        cnt_b <= ld_val_b;
      else if (tick_b) cnt_b <= nxt_b;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.fused && en_a && cfg.stall_a && halt && !ld_a) |=> $stable(cnt_a));
endmodule

// File: rtl/split_timer.sv
module split_timer
  import st_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [2:0]            addr,
  input  logic [2*HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0]   rdata,
  input  logic                  halt,
  input  logic                  rtc_clk,
  output logic                  irq_to_a,
  output logic                  irq_to_b,
  output logic                  irq_match
);
  localparam int DATA_W = 2 * HALF_W;
  localparam int CFG_W  = $bits(cfg_t);

  cfg_t              cfg;
  logic              en_a, en_b;
  logic [HALF_W-1:0] rel_a, rel_b, cnt_a, cnt_b, ld_val_b;
  logic [DATA_W-1:0] match_r, rd_mux;
  logic [PRE_W-1:0]  pre_v  [2];
  logic              en_v   [2];
  logic              stl_v  [2];
  logic              wrap_v [2];
  logic              rtc_rise, ev_to_a, ev_to_b, ev_match, done_a, done_b;
  logic              cfg_wr, ctl_wr, load_wr, loadb_wr, flag_wr, ld_a, ld_b;

  reg_addr_e a_sel;
  assign a_sel    = reg_addr_e'(addr);
  assign cfg_wr   = wr_en && a_sel == A_CFG;
  assign ctl_wr   = wr_en && a_sel == A_CTL;
  assign load_wr  = wr_en && a_sel == A_LOAD;
  assign loadb_wr = wr_en && a_sel == A_LOADB;
  assign flag_wr  = wr_en && a_sel == A_FLAG;
  assign ld_a     = load_wr && !en_a;
  assign ld_b     = loadb_wr && !en_b && !cfg.fused;
  assign ld_val_b = cfg.fused ? wdata[DATA_W-1:HALF_W] : wdata[HALF_W-1:0];

  assign en_v[0]  = en_a;
  assign en_v[1]  = en_b;
  assign stl_v[0] = cfg.stall_a;
  assign stl_v[1] = cfg.stall_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      en_a    <= 1'b0;
      en_b    <= 1'b0;
      rel_a   <= '0;
      rel_b   <= '0;
      match_r <= '0;
      pre_v[0] <= '0;
      pre_v[1] <= '0;
    end else begin
      if (cfg_wr && !en_a && !en_b) cfg <= cfg_t'(wdata[CFG_W-1:0]);
      if (ctl_wr)      en_a <= wdata[0];
      else if (done_a) en_a <= 1'b0;
      if (ctl_wr)      en_b <= wdata[1];
      else if (done_b) en_b <= 1'b0;
      if (load_wr) begin
        rel_a <= wdata[HALF_W-1:0];
        if (cfg.fused) rel_b <= wdata[DATA_W-1:HALF_W];
      end
      if (loadb_wr) rel_b <= wdata[HALF_W-1:0];
      if (wr_en && a_sel == A_MATCH) match_r <= wdata;
      if (wr_en && a_sel == A_PRE) begin
        pre_v[0] <= wdata[PRE_W-1:0];
        pre_v[1] <= wdata[2*PRE_W-1:PRE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_to_a  <= 1'b0;
      irq_to_b  <= 1'b0;
      irq_match <= 1'b0;
    end else begin
      irq_to_a  <= (irq_to_a  && !(flag_wr && wdata[0])) || ev_to_a;
      irq_to_b  <= (irq_to_b  && !(flag_wr && wdata[1])) || ev_to_b;
      irq_match <= (irq_match && !(flag_wr && wdata[2])) || ev_match;
    end
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pre
      st_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .active (en_v[g] && !cfg.fused),
        .hold   (stl_v[g] && halt),
        .preset (pre_v[g]),
        .wrap   (wrap_v[g])
      );
    end
  endgenerate

  st_edge_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (rtc_clk),
    .rise     (rtc_rise)
  );

  st_core #(.HALF_W(HALF_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .cfg        (cfg),
    .en_a       (en_a),
    .en_b       (en_b),
    .halt       (halt),
    .pre_wrap_a (wrap_v[0]),
    .pre_wrap_b (wrap_v[1]),
    .rtc_rise   (rtc_rise),
    .ld_a       (ld_a),
    .ld_b       (ld_b),
    .ld_val_a   (wdata[HALF_W-1:0]),
    .ld_val_b   (ld_val_b),
    .rel_a      (rel_a),
    .rel_b      (rel_b),
    .match      (match_r),
    .cnt_a      (cnt_a),
    .cnt_b      (cnt_b),
    .ev_to_a    (ev_to_a),
    .ev_to_b    (ev_to_b),
    .ev_match   (ev_match),
    .done_a     (done_a),
    .done_b     (done_b)
  );

  always_comb begin
    rd_mux = '0;
    case (a_sel)
      A_CFG:   rd_mux = {{(DATA_W-CFG_W){1'b0}}, cfg};
      A_CTL:   rd_mux = {{(DATA_W-2){1'b0}}, en_b, en_a};
      A_LOAD:  rd_mux = {rel_b, rel_a};
      A_LOADB: rd_mux = {{HALF_W{1'b0}}, rel_b};
      A_MATCH: rd_mux = match_r;
      A_PRE:   rd_mux = {{(DATA_W-2*PRE_W){1'b0}}, pre_v[1], pre_v[0]};
      A_FLAG:  rd_mux = {{(DATA_W-3){1'b0}}, irq_match, irq_to_b, irq_to_a};
      A_CNT:   rd_mux = {cnt_b, cnt_a};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R10
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (en_a || en_b) |=> $stable(cfg));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_to_a && !(flag_wr && wdata[0])) |=> irq_to_a);

  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (done_a && !ctl_wr) |=> !en_a);
endmodule

// File: tb/tb_split_timer.sv
module tb_split_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        halt = 1'b0;
  logic        rtc_clk = 1'b0;
  logic        irq_to_a, irq_to_b, irq_match;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  split_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .halt(halt), .rtc_clk(rtc_clk),
    .irq_to_a(irq_to_a), .irq_to_b(irq_to_b), .irq_match(irq_match)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 32'h0, 32'h0000_0000},
    '{1'b0, 3'd1, 32'h0, 32'h0000_0000},
    '{1'b0, 3'd6, 32'h0, 32'h0000_0000},
    '{1'b0, 3'd7, 32'h0, 32'h0000_0000},
    '{1'b0, 3'd4, 32'h0, 32'h0000_0000},
    '{1'b1, 3'd5, 32'h0000_1234, 32'h0},
    '{1'b0, 3'd5, 32'h0, 32'h0000_1234},
    '{1'b1, 3'd4, 32'hDEAD_BEEF, 32'h0},
    '{1'b0, 3'd4, 32'h0, 32'hDEAD_BEEF},
    '{1'b1, 3'd0, 32'h0000_003F, 32'h0},
    '{1'b0, 3'd0, 32'h0, 32'h0000_003F},
    '{1'b1, 3'd0, 32'h0000_0000, 32'h0},
    '{1'b1, 3'd2, 32'hABCD_1234, 32'h0},
    '{1'b0, 3'd2, 32'h0, 32'h0000_1234},
    '{1'b0, 3'd7, 32'h0, 32'h0000_1234},
    '{1'b1, 3'd3, 32'h0000_5678, 32'h0},
    '{1'b0, 3'd3, 32'h0, 32'h0000_5678},
    '{1'b0, 3'd7, 32'h0, 32'h5678_1234},
    '{1'b1, 3'd5, 32'h0000_0000, 32'h0},
    '{1'b1, 3'd4, 32'h0000_0000, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic rtc_pulse();
    rtc_clk = 1'b1;
    repeat (4) @(negedge clk);
    rtc_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 outputs at reset
    check("R1", {29'h0, irq_match, irq_to_b, irq_to_a}, 32'h0);
    check("R1", rdata, 32'h0);

    // R1 R2 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        check("R1 R2 R9", v, VEC[i].exp);
      end
    end

    // R3 R5: one-shot A, load 2, prescale 3 -> timeout 12 clocks after enable
    wr(3'd2, 32'd2);
    wr(3'd5, 32'd3);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h1);
    repeat (11) @(negedge clk);
    check("R5", {31'h0, irq_to_a}, 32'h0);
    @(negedge clk);
    check("R5", {31'h0, irq_to_a}, 32'h1);
    rd(3'd1, v);
    check("R3", v, 32'h0);
    repeat (10) @(negedge clk);
    rd(3'd7, v);
    check("R3", {16'h0, v[15:0]}, 32'h0);
    wr(3'd6, 32'h1);
    check("R11", {31'h0, irq_to_a}, 32'h0);

    // R4: periodic A, load 3, no prescale
    wr(3'd5, 32'h0);
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h04);
    wr(3'd1, 32'h1);
    repeat (3) @(negedge clk);
    check("R4", {31'h0, irq_to_a}, 32'h0);
    @(negedge clk);
    check("R4", {31'h0, irq_to_a}, 32'h1);
    wr(3'd6, 32'h1);
    repeat (2) @(negedge clk);
    check("R4", {31'h0, irq_to_a}, 32'h0);
    @(negedge clk);
    check("R4", {31'h0, irq_to_a}, 32'h1);
    // R9: load while running does not move the count
    wr(3'd2, 32'd16);
    rd(3'd7, v);
    check("R9", {31'h0, (v[15:0] <= 16'd3)}, 32'h1);
    wr(3'd1, 32'h0);

    // R11: clear in the same cycle as an event
    wr(3'd2, 32'd0);
    wr(3'd1, 32'h1);
    wr(3'd6, 32'h1);
    check("R11", {31'h0, irq_to_a}, 32'h1);
    wr(3'd1, 32'h0);
    wr(3'd6, 32'h7);
    check("R11", {29'h0, irq_match, irq_to_b, irq_to_a}, 32'h0);

    // R10: config write ignored while enabled
    wr(3'd2, 32'd100);
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h01);
    rd(3'd0, v);
    check("R10", v, 32'h04);
    wr(3'd1, 32'h0);

    // R8: stall A on halt, B keeps counting
    wr(3'd0, 32'h10);
    wr(3'd2, 32'd100);
    wr(3'd3, 32'd100);
    halt = 1'b1;
    wr(3'd1, 32'h3);
    repeat (20) @(negedge clk);
    rd(3'd7, v);
    check("R8", v, 32'h0050_0064);
    halt = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd7, v);
    check("R8", v, 32'h0045_005A);
    wr(3'd1, 32'h0);
    wr(3'd6, 32'h7);

    // R6: fused 32-bit, borrow across halves, prescale ignored
    wr(3'd5, 32'h0505);
    wr(3'd0, 32'h01);
    wr(3'd2, 32'h0001_0002);
    rd(3'd7, v);
    check("R6", v, 32'h0001_0002);
    wr(3'd1, 32'h1);
    repeat (2) @(negedge clk);
    rd(3'd7, v);
    check("R6", v, 32'h0001_0000);
    rd(3'd7, v);
    check("R6", v, 32'h0000_FFFF);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'd40);
    wr(3'd1, 32'h1);
    repeat (40) @(negedge clk);
    check("R6", {31'h0, irq_to_a}, 32'h0);
    @(negedge clk);
    check("R6", {31'h0, irq_to_a}, 32'h1);
    rd(3'd1, v);
    check("R6", v, 32'h0);
    wr(3'd6, 32'h7);

    // R7: RTC mode counts external edges only, wraps, match flag
    wr(3'd0, 32'h03);
    wr(3'd4, 32'h1);
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd1, 32'h1);
    repeat (30) @(negedge clk);
    rd(3'd7, v);
    check("R7", v, 32'hFFFF_FFFE);
    rtc_pulse();
    rtc_pulse();
    rd(3'd7, v);
    check("R7", v, 32'h0);
    check("R7", {31'h0, irq_match}, 32'h0);
    rtc_pulse();
    check("R7", {31'h0, irq_match}, 32'h1);
    check("R7", {31'h0, irq_to_a}, 32'h0);
    rd(3'd7, v);
    check("R7", v, 32'h1);
    wr(3'd6, 32'h4);
    check("R11", {31'h0, irq_match}, 32'h0);
    wr(3'd1, 32'h0);

    finish_run();
  end
endmodule